// File: doc/BRIEF.md
# Branch Opcode Classifier

This block labels a recorded control-flow change with one branch type. It looks at the leading opcode bytes of the instruction at the branch source, the ModRM byte, a flag that says whether the 32-bit displacement of a relative call is zero, and the privilege level of the source and of the target. It also takes an abort flag, a flag for each address that says it is zero, and a strobe that says the opcode bytes could be read at all. The result is a one-hot type code, ORed with one bit that gives the privilege of the branch target.

It is used as a filtering stage behind a branch-record buffer. A branch-sampling unit compares the code against a requested type mask and keeps or drops the entry. The result is registered: it appears one cycle after a valid input, together with an output-valid pulse. Fetching the instruction bytes and working out full instruction lengths are done elsewhere.

A ring transition can happen on any instruction. For that reason the block folds the privilege movement into the type: a user-to-kernel change that is not a system call or software interrupt is reported as an interrupt or fault. A relative call with a zero displacement is reported as its own zero-length-call type.

Top module: `brc_classifier`

## Requirements
- R1: If `src_zero` or `dst_zero` is set, the code is all zeros, whatever the other inputs are.
- R2: If no address is zero and `abort_in` is set, the code is abort (bit 12) ORed with the target privilege bit (kernel bit 1 when `dst_kernel`=1, else user bit 0), whatever the opcode and privilege transition are.
- R3: If no address is zero, `abort_in` is clear and `op_ok` is low, the code is abort (bit 12) alone, with no privilege bit.
- R4: With lead byte 0x0F, the second byte selects the type: 0x05 or 0x34 give syscall (bit 4), 0x07 or 0x35 give sysret (bit 5), and 0x80 to 0x8F give conditional (bit 8). Any other second byte gives none.
- R5: Lead bytes 0x70 to 0x7F and 0xE0 to 0xE3 give conditional (bit 8). 0xC2, 0xC3, 0xCA and 0xCB give return (bit 3). 0xCF gives interrupt return (bit 7). 0xCC to 0xCE give software interrupt (bit 6).
- R6: Lead byte 0xE8 gives zero-length call (bit 15) when `imm_zero`=1 and call (bit 2) otherwise. 0x9A gives call (bit 2). 0xE9 to 0xEB give jump (bit 9). Lead bytes not listed in R4 to R7 give none.
- R7: With lead byte 0xFF, the ModRM reg field (bits 5:3) selects the type: 2 or 3 give indirect call (bit 11), and 4 or 5 give indirect jump (bit 17). Other values give none. ModRM bits 7:6 and 2:0 have no effect.
- R8: If `src_kernel`=0 and `dst_kernel`=1 and the decoded type is neither syscall nor software interrupt, the type becomes irq (bit 10). This includes a decoded type of none.
- R9: A non-none type from R4 to R8 is ORed with exactly one privilege bit: kernel (bit 1) when `dst_kernel`=1, user (bit 0) otherwise. A none type gives an all-zero code.
- R10: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. `br_class` takes the new code at that edge and holds its value while `in_valid` is low. After reset both are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input record is valid this cycle |
| op_ok | input | 1 | Opcode bytes were readable |
| lead_byte | input | 8 | First opcode byte |
| second_byte | input | 8 | Second opcode byte (after 0x0F) |
| modrm | input | 8 | ModRM byte |
| imm_zero | input | 1 | 32-bit call displacement is zero |
| src_kernel | input | 1 | Branch source is kernel level |
| dst_kernel | input | 1 | Branch target is kernel level |
| abort_in | input | 1 | Record marks a transaction abort |
| src_zero | input | 1 | Source address is zero |
| dst_zero | input | 1 | Target address is zero |
| out_valid | output | 1 | Code on `br_class` is new this cycle |
| br_class | output | 18 | One-hot type code ORed with target privilege bit |

## Verification
The bench works through the order of precedence. A zero address must override an abort and an unreadable opcode, and an abort must override the user-to-kernel fold. A design with any of these swapped gives irq or abort where all zeros or abort are expected. It covers both edges of each opcode range, and zero and non-zero call displacement. It sends ModRM values whose mod and r/m bits are set, to catch a decoder that reads the wrong field. It also covers the fold applied to an unknown opcode, and the fold held back for system calls and software interrupts. A design that attached the privilege bit before the fold, or not at all, would produce a code with two privilege bits or a bare type.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int BYTE_W  = 8;
  localparam int TYPE_W  = 18;
  localparam int REG_W   = 3;

  localparam int B_USER     = 0;
  localparam int B_KERNEL   = 1;
  localparam int B_CALL     = 2;
  localparam int B_RET      = 3;
  localparam int B_SYSCALL  = 4;
  localparam int B_SYSRET   = 5;
  localparam int B_INT      = 6;
  localparam int B_IRET     = 7;
  localparam int B_COND     = 8;
  localparam int B_JUMP     = 9;
  localparam int B_IRQ      = 10;
  localparam int B_INDCALL  = 11;
  localparam int B_ABORT    = 12;
  localparam int B_ZCALL    = 15;
  localparam int B_INDJMP   = 17;

  typedef logic [TYPE_W-1:0] brtype_t;

  function automatic brtype_t tbit(input int pos);
    return brtype_t'(1) << pos;
  endfunction

  localparam brtype_t PRIV_MASK = brtype_t'(3);
endpackage

// File: rtl/brc_opdecode.sv
module brc_opdecode
  import brc_pkg::*;
(
  input  logic [BYTE_W-1:0] lead_byte,
  input  logic [BYTE_W-1:0] second_byte,
  input  logic [REG_W-1:0]  modrm_reg,
  input  logic              imm_zero,
  output brtype_t           raw_type,
  output logic              ring_entry
);
  function automatic brtype_t decode_escape(input logic [BYTE_W-1:0] b);
    case (b) inside
      8'h05, 8'h34:      return tbit(B_SYSCALL);
      8'h07, 8'h35:      return tbit(B_SYSRET);
      [8'h80:8'h8F]:     return tbit(B_COND);
      default:           return '0;
    endcase
  endfunction

  function automatic brtype_t decode_group(input logic [REG_W-1:0] r);
    case (r)
      3'd2, 3'd3: return tbit(B_INDCALL);
      3'd4, 3'd5: return tbit(B_INDJMP);
      default:    return '0;
    endcase
  endfunction

  function automatic brtype_t decode_lead(input logic [BYTE_W-1:0] b0,
                                         input logic [BYTE_W-1:0] b1,
                                         input logic [REG_W-1:0]  r,
                                         input logic              iz);
    case (b0) inside
      8'h0F:                       return decode_escape(b1);
      [8'h70:8'h7F], [8'hE0:8'hE3]: return tbit(B_COND);
      8'hC2, 8'hC3, 8'hCA, 8'hCB:  return tbit(B_RET);
      8'hCF:                       return tbit(B_IRET);
      [8'hCC:8'hCE]:               return tbit(B_INT);
      8'hE8:                       return iz ? tbit(B_ZCALL) : tbit(B_CALL);
      8'h9A:                       return tbit(B_CALL);
      [8'hE9:8'hEB]:               return tbit(B_JUMP);
      8'hFF:                       return decode_group(r);
      default:                     return '0;
    endcase
  endfunction

  always_comb begin
    raw_type   = decode_lead(lead_byte, second_byte, modrm_reg, imm_zero);
    ring_entry = raw_type[B_SYSCALL] | raw_type[B_INT];
  end
endmodule

// File: rtl/brc_privfold.sv
module brc_privfold
  import brc_pkg::*;
(
  input  brtype_t raw_type,
  input  logic    ring_entry,
  input  logic    op_ok,
  input  logic    abort_in,
  input  logic    src_kernel,
  input  logic    dst_kernel,
  input  logic    src_zero,
  input  logic    dst_zero,
  output brtype_t final_type,
  output logic    fold_to_irq
);
  brtype_t tgt_priv;
  brtype_t folded;
  logic    ring_cross;

  always_comb begin
    tgt_priv    = dst_kernel ? tbit(B_KERNEL) : tbit(B_USER);
    ring_cross  = !src_kernel && dst_kernel;
    fold_to_irq = ring_cross && !ring_entry;
    folded      = fold_to_irq ? tbit(B_IRQ) : raw_type;

    if (src_zero || dst_zero)
      final_type = '0;
    else if (abort_in)
      final_type = tbit(B_ABORT) | tgt_priv;
    else if (!op_ok)
      final_type = tbit(B_ABORT);
    else if (folded == '0)
      final_type = '0;
    else
      final_type = folded | tgt_priv;
  end
endmodule

// File: rtl/brc_classifier.sv
module brc_classifier
  import brc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                op_ok,
  input  logic [BYTE_W-1:0]   lead_byte,
  input  logic [BYTE_W-1:0]   second_byte,
  input  logic [BYTE_W-1:0]   modrm,
  input  logic                imm_zero,
  input  logic                src_kernel,
  input  logic                dst_kernel,
  input  logic                abort_in,
  input  logic                src_zero,
  input  logic                dst_zero,
  output logic                out_valid,
  output logic [TYPE_W-1:0]   br_class
);
  localparam int REG_LSB = 3;

  logic [REG_W-1:0] modrm_reg;
  brtype_t          raw_type;
  brtype_t          next_class;
  logic             ring_entry;
  logic             fold_to_irq;
  logic             unused_modrm;

  assign modrm_reg    = modrm[REG_LSB +: REG_W];
  assign unused_modrm = &{1'b0, modrm[BYTE_W-1:REG_LSB+REG_W], modrm[REG_LSB-1:0]};

  brc_opdecode u_dec (
    .lead_byte   (lead_byte),
    .second_byte (second_byte),
    .modrm_reg   (modrm_reg),
    .imm_zero    (imm_zero),
    .raw_type    (raw_type),
    .ring_entry  (ring_entry)
  );

  brc_privfold u_fold (
    .raw_type    (raw_type),
    .ring_entry  (ring_entry),
    .op_ok       (op_ok),
    .abort_in    (abort_in),
    .src_kernel  (src_kernel),
    .dst_kernel  (dst_kernel),
    .src_zero    (src_zero),
    .dst_zero    (dst_zero),
    .final_type  (next_class),
    .fold_to_irq (fold_to_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      br_class  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        br_class <= next_class;
    end
  end

  // R10: output-valid follows input-valid by one cycle
  p_valid_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10: code holds while no new input arrives
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(br_class));
  // R1: zero address gives empty code
  p_zero_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (src_zero || dst_zero) |=> br_class == '0);
  // R2: abort carries target privilege only
  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && abort_in && !src_zero && !dst_zero |=>
      br_class == (tbit(B_ABORT) | ($past(dst_kernel) ? tbit(B_KERNEL) : tbit(B_USER))));
  // R3: unreadable opcode reports bare abort
  p_undecodable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op_ok && !abort_in && !src_zero && !dst_zero |=> br_class == tbit(B_ABORT));
  // R8: user-to-kernel non-entry change lands on irq
  p_fold_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_ok && !abort_in && !src_zero && !dst_zero && fold_to_irq |=>
      br_class == (tbit(B_IRQ) | tbit(B_KERNEL)));
  // R9: at most one type bit and at most one privilege bit
  p_type_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(br_class & ~PRIV_MASK));
  p_priv_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(br_class & PRIV_MASK));
endmodule

// File: tb/brc_classifier_tb.sv
module brc_classifier_tb;
  localparam int CLK_NS = 20;
  localparam int VW = 53;
  // flags: {op_ok, imm_zero, src_kernel, dst_kernel, abort, src_zero, dst_zero}
  localparam logic [6:0] F_UU = 7'b1000000;
  localparam logic [6:0] F_KK = 7'b1011000;
  localparam logic [6:0] F_KU = 7'b1010000;
  localparam logic [6:0] F_UK = 7'b1001000;
  localparam logic [6:0] F_IZ = 7'b1100000;
  localparam int NV = 52;
  // row: {req, lead, second, modrm, flags, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd4, 8'h0F, 8'h05, 8'h00, F_UU, 18'h00011},   // R4 syscall
    {4'd4, 8'h0F, 8'h34, 8'h00, F_KK, 18'h00012},   // R4
    {4'd4, 8'h0F, 8'h07, 8'h00, F_KU, 18'h00021},   // R4 sysret
    {4'd4, 8'h0F, 8'h35, 8'h00, F_UU, 18'h00021},   // R4
    {4'd4, 8'h0F, 8'h80, 8'h00, F_UU, 18'h00101},   // R4 cond low edge
    {4'd4, 8'h0F, 8'h8F, 8'h00, F_KK, 18'h00102},   // R4 cond high edge
    {4'd4, 8'h0F, 8'h06, 8'h00, F_UU, 18'h00000},   // R4 none
    {4'd4, 8'h0F, 8'h90, 8'h00, F_KK, 18'h00000},   // R4 none past range
    {4'd4, 8'h0F, 8'h7F, 8'h00, F_UU, 18'h00000},   // R4 none below range
    {4'd5, 8'h70, 8'h00, 8'h00, F_UU, 18'h00101},   // R5
    {4'd5, 8'h7F, 8'h00, 8'h00, F_KK, 18'h00102},   // R5
    {4'd5, 8'hE0, 8'h00, 8'h00, F_UU, 18'h00101},   // R5 loop
    {4'd5, 8'hE3, 8'h00, 8'h00, F_KK, 18'h00102},   // R5
    {4'd5, 8'hC2, 8'h00, 8'h00, F_UU, 18'h00009},   // R5 return
    {4'd5, 8'hC3, 8'h00, 8'h00, F_UU, 18'h00009},   // R5
    {4'd5, 8'hCA, 8'h00, 8'h00, F_UU, 18'h00009},   // R5
    {4'd5, 8'hCB, 8'h00, 8'h00, F_KK, 18'h0000A},   // R5
    {4'd5, 8'hCF, 8'h00, 8'h00, F_KU, 18'h00081},   // R5 iret
    {4'd5, 8'hCC, 8'h00, 8'h00, F_UU, 18'h00041},   // R5 int
    {4'd5, 8'hCE, 8'h00, 8'h00, F_KK, 18'h00042},   // R5
    {4'd5, 8'h6F, 8'h00, 8'h00, F_UU, 18'h00000},   // R5 below range -> none
    {4'd6, 8'hE8, 8'h00, 8'h00, F_IZ, 18'h08001},   // R6 zero-length call
    {4'd6, 8'hE8, 8'h00, 8'h00, F_UU, 18'h00005},   // R6 call
    {4'd6, 8'h9A, 8'h00, 8'h00, F_KK, 18'h00006},   // R6 far call
    {4'd6, 8'hE9, 8'h00, 8'h00, F_UU, 18'h00201},   // R6 jump
    {4'd6, 8'hEB, 8'h00, 8'h00, F_KK, 18'h00202},   // R6
    {4'd6, 8'hE4, 8'h00, 8'h00, F_UU, 18'h00000},   // R6 unlisted
    {4'd6, 8'h90, 8'h00, 8'h00, F_KK, 18'h00000},   // R6 unlisted
    {4'd7, 8'hFF, 8'h00, 8'h10, F_UU, 18'h00801},   // R7 reg 2
    {4'd7, 8'hFF, 8'h00, 8'h18, F_KK, 18'h00802},   // R7 reg 3
    {4'd7, 8'hFF, 8'h00, 8'h20, F_UU, 18'h20001},   // R7 reg 4
    {4'd7, 8'hFF, 8'h00, 8'h28, F_UU, 18'h20001},   // R7 reg 5
    {4'd7, 8'hFF, 8'h00, 8'h30, F_UU, 18'h00000},   // R7 reg 6
    {4'd7, 8'hFF, 8'h00, 8'h07, F_UU, 18'h00000},   // R7 reg 0 with rm set
    {4'd7, 8'hFF, 8'h00, 8'hD7, F_KK, 18'h00802},   // R7 mod/rm bits ignored
    {4'd7, 8'hFF, 8'h00, 8'hE8, F_UU, 18'h20001},   // R7 mod bits ignored
    {4'd8, 8'h0F, 8'h05, 8'h00, F_UK, 18'h00012},   // R8 syscall not folded
    {4'd8, 8'hCD, 8'h00, 8'h00, F_UK, 18'h00042},   // R8 int not folded
    {4'd8, 8'hC3, 8'h00, 8'h00, F_UK, 18'h00402},   // R8 fold
    {4'd8, 8'h90, 8'h00, 8'h00, F_UK, 18'h00402},   // R8 unknown folds
    {4'd8, 8'hFF, 8'h00, 8'h10, F_UK, 18'h00402},   // R8
    {4'd8, 8'h0F, 8'h07, 8'h00, F_UK, 18'h00402},   // R8 sysret folds
    {4'd9, 8'hC3, 8'h00, 8'h00, F_KU, 18'h00009},   // R9 kernel->user no fold
    {4'd9, 8'h70, 8'h00, 8'h00, F_KK, 18'h00102},   // R9 kernel bit
    {4'd2, 8'hC3, 8'h00, 8'h00, 7'b1000100, 18'h01001}, // R2 abort user
    {4'd2, 8'hCD, 8'h00, 8'h00, 7'b1001100, 18'h01002}, // R2 abort beats fold
    {4'd2, 8'h90, 8'h00, 8'h00, 7'b0001100, 18'h01002}, // R2 abort beats op_ok
    {4'd1, 8'hC3, 8'h00, 8'h00, 7'b1000110, 18'h00000}, // R1 src zero over abort
    {4'd1, 8'hC3, 8'h00, 8'h00, 7'b1001001, 18'h00000}, // R1 dst zero
    {4'd1, 8'h90, 8'h00, 8'h00, 7'b0000010, 18'h00000}, // R1 over op_ok low
    {4'd3, 8'hC3, 8'h00, 8'h00, 7'b0000000, 18'h01000}, // R3 bare abort
    {4'd3, 8'hE8, 8'h00, 8'h00, 7'b0001000, 18'h01000}  // R3 no fold, no priv
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic op_ok = 1'b0;
  logic [7:0] lead_byte = '0, second_byte = '0, modrm = '0;
  logic imm_zero = 1'b0, src_kernel = 1'b0, dst_kernel = 1'b0;
  logic abort_in = 1'b0, src_zero = 1'b0, dst_zero = 1'b0;
  logic out_valid;
  logic [17:0] br_class;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  brc_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_ok(op_ok),
    .lead_byte(lead_byte), .second_byte(second_byte), .modrm(modrm),
    .imm_zero(imm_zero), .src_kernel(src_kernel), .dst_kernel(dst_kernel),
    .abort_in(abort_in), .src_zero(src_zero), .dst_zero(dst_zero),
    .out_valid(out_valid), .br_class(br_class)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v, input logic vld);
    lead_byte   = v[48:41];
    second_byte = v[40:33];
    modrm       = v[32:25];
    {op_ok, imm_zero, src_kernel, dst_kernel, abort_in, src_zero, dst_zero} = v[24:18];
    in_valid    = vld;
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset valid", 32'(out_valid), 32'd0);
    check("R10 reset class", 32'(br_class), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle valid", 32'(out_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d row %0d", VEC[i][52:49], i), 32'(br_class), 32'(VEC[i][17:0]));
      check("R10 valid after input", 32'(out_valid), 32'd1);
    end

    // R10 hold: new data without in_valid must not change code
    drive({4'd10, 8'hC3, 8'h00, 8'h00, F_UK, 18'h0}, 1'b1);
    @(negedge clk);
    check("R10 loaded", 32'(br_class), 32'h402);
    drive({4'd10, 8'h70, 8'h00, 8'h00, F_UU, 18'h0}, 1'b0);
    @(negedge clk);
    check("R10 hold class", 32'(br_class), 32'h402);
    check("R10 valid low", 32'(out_valid), 32'd0);
    @(negedge clk);
    check("R10 hold class 2", 32'(br_class), 32'h402);

    // R10 back-to-back records
    drive({4'd10, 8'hE9, 8'h00, 8'h00, F_UU, 18'h0}, 1'b1);
    @(negedge clk);
    check("R10 b2b first", 32'(br_class), 32'h201);
    drive({4'd10, 8'hE8, 8'h00, 8'h00, F_IZ, 18'h0}, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 b2b second", 32'(br_class), 32'h8001);
    check("R10 b2b valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R10 b2b valid drop", 32'(out_valid), 32'd0);

    // R10 reset clears a loaded code
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears", 32'(br_class), 32'd0);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule